// File: doc/BRIEF.md
# BCD Real-Time Clock Register Bank

This block keeps calendar time as packed BCD counters: seconds, minutes, hours, day of week, day of month, month, a two-digit year and a century flag. A one-cycle pulse on the seconds input advances the counters. The advance carries through every field and takes account of month lengths and leap years. Software reaches the block through eight byte-wide registers on a plain synchronous bus: a 3-bit address, a write strobe, write data, and read data that follows the address in the same cycle.

Software never reads or writes the running counters directly. It sees a separate copy, refreshed from the counters on every clock while neither freeze flag in the control register is set. With the load flag set, the copy stops tracking and accepts time writes. Clearing the load flag copies the whole copy into the counters in a single cycle. With the snapshot flag set, the copy holds a coherent reading while the counters keep running. A stop bit pauses counting. A century-enable bit decides whether the century flag flips when the year wraps. Calibration, frequency-test and battery-alarm-enable bits are plain storage.

Top module: `rtc_bcd_bank`

## Requirements
- R1: After reset the registers read: offset 0 = 0x00, seconds 0x00, minutes 0x00, hours 0x00, offset 4 = 0x01 (day of week 1), date 0x01, month 0x01, year 0x00.
- R2: Each accepted tick adds one second in BCD. Seconds wrap 59→00 into minutes, minutes 59→00 into hours, and hours 23→00 into date and day of week. Day of week (offset 4 bits 2..0) counts 1..7 and wraps 7→1.
- R3: The date (offset 5 bits 5..0, BCD) wraps to 01 after 31, 30, 29 or 28. Months 04, 06, 09 and 11 end at 30. Month 02 ends at 29 when the binary value of the year is divisible by 4, and at 28 otherwise. Every other month ends at 31.
- R4: The month (offset 6 bits 4..0) wraps 12→01 and carries into the year (offset 7, two BCD digits), which wraps 99→00.
- R5: The century flag (offset 4 bit 4) inverts when the year wraps 99→00, but only while century-enable (offset 4 bit 5) is 1.
- R6: While the load flag (offset 0 bit 7) is 1, the visible time fields do not follow ticks. Writes to offsets 1..7 update the visible fields and read back at once.
- R7: A control write with bit 7 = 0 while the load flag is 1 copies all seven visible time registers into the counters in that cycle. A tick in that same cycle is discarded, and the loaded value is readable one cycle later.
- R8: While the load flag is 0, writes to the time fields of offsets 1..7 have no effect.
- R9: While the snapshot flag (offset 0 bit 6) is 1, the visible fields hold still while the counters keep counting. One cycle after the flag is cleared, the reads show the advanced count.
- R10: While stop (offset 1 bit 7) is 1, ticks are ignored. After stop is cleared, counting resumes from the held value.
- R11: Bits that are always zero read 0 whatever is written: offset 2 bit 7, offset 3 bits 7..6, offset 4 bits 7 and 3, offset 5 bit 6 (battery flag, read-only), and offset 6 bits 7..5.
- R12: Control bits 5..0 (calibration sign and magnitude), stop, frequency-test (offset 4 bit 6), century-enable and battery-alarm-enable (offset 5 bit 7) are written directly, whatever the state of the load flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_1hz | input | 1 | One-cycle pulse per second from the prescaler |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, same cycle |

## Verification
A behavioural calendar model runs in step with the design and is compared on every clock. It is driven by several patterns. Single ticks from mid-minute values tell a plain BCD digit step apart from a decade carry. Loads just before midnight on the last day of January, February in leap and common years, April and December in year 99 separate the four month lengths, the leap rule and the year wrap. The wrap is tried with century-enable both set and clear. Ticks issued while stopped, during the snapshot, during the load, and in the same cycle as the load release show which path feeds the counters and which feeds the visible copy.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int REG_ADDR_W = 3;
    localparam int REG_DATA_W = 8;

    localparam logic [REG_ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [REG_ADDR_W-1:0] A_SEC  = 3'd1;
    localparam logic [REG_ADDR_W-1:0] A_MIN  = 3'd2;
    localparam logic [REG_ADDR_W-1:0] A_HR   = 3'd3;
    localparam logic [REG_ADDR_W-1:0] A_DAY  = 3'd4;
    localparam logic [REG_ADDR_W-1:0] A_DATE = 3'd5;
    localparam logic [REG_ADDR_W-1:0] A_MON  = 3'd6;
    localparam logic [REG_ADDR_W-1:0] A_YEAR = 3'd7;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hr;
        logic [2:0] dow;
        logic [5:0] date;
        logic [4:0] mon;
        logic [7:0] yr;
        logic       cb;
    } rtc_time_t;

    typedef struct packed {
        logic       wr_f;
        logic       rd_f;
        logic       cal_sign;
        logic [4:0] cal_mag;
        logic       stop;
        logic       ftest;
        logic       cen;
        logic       ble;
        rtc_time_t  live;
        rtc_time_t  vis;
    } rtc_state_t;

    localparam rtc_time_t TIME_RST = '{sec: 7'h00, min: 7'h00, hr: 6'h00,
                                       dow: 3'd1, date: 6'h01, mon: 5'h01,
                                       yr: 8'h00, cb: 1'b0};

    localparam rtc_state_t STATE_RST = '{wr_f: 1'b0, rd_f: 1'b0, cal_sign: 1'b0,
                                         cal_mag: 5'd0, stop: 1'b0, ftest: 1'b0,
                                         cen: 1'b0, ble: 1'b0,
                                         live: TIME_RST, vis: TIME_RST};

    // Returns {wrapped, next}: BCD increment, or base once top is reached.
    function automatic logic [8:0] bcd_step(input logic [7:0] v,
                                            input logic [7:0] top,
                                            input logic [7:0] base);
        logic [7:0] n;
        if (v >= top) begin
            return {1'b1, base};
        end
        if (v[3:0] >= 4'd9) n = {v[7:4] + 4'd1, 4'd0};
        else                n = v + 8'd1;
        return {1'b0, n};
    endfunction

endpackage

// File: rtl/rtc_month_len.sv
module rtc_month_len
    import rtc_pkg::*;
(
    input  logic [4:0] mon_bcd,
    input  logic [7:0] yr_bcd,
    output logic [5:0] last_bcd
);
    // year mod 4 == (2*tens + units) mod 4
    logic [4:0] yr_mod_sum;
    logic       leap;

    always_comb begin
        yr_mod_sum = {yr_bcd[7:4], 1'b0} + {1'b0, yr_bcd[3:0]};
        leap       = (yr_mod_sum[1:0] == 2'b00);
        case (mon_bcd)
            5'h02:                      last_bcd = leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: last_bcd = 6'h30;
            default:                    last_bcd = 6'h31;
        endcase
    end
endmodule

// File: rtl/rtc_time_adv.sv
module rtc_time_adv
    import rtc_pkg::*;
(
    input  rtc_time_t cur,
    input  logic      cen,
    output rtc_time_t nxt
);
    logic [5:0] last_day;
    logic [8:0] s_sec, s_min, s_hr, s_dow, s_date, s_mon, s_yr;
    logic       step_unused;

    rtc_month_len u_len (
        .mon_bcd (cur.mon),
        .yr_bcd  (cur.yr),
        .last_bcd(last_day)
    );

    always_comb begin
        s_sec  = bcd_step({1'b0, cur.sec}, 8'h59, 8'h00);
        s_min  = bcd_step({1'b0, cur.min}, 8'h59, 8'h00);
        s_hr   = bcd_step({2'b0, cur.hr}, 8'h23, 8'h00);
        s_dow  = bcd_step({5'b0, cur.dow}, 8'h07, 8'h01);
        s_date = bcd_step({2'b0, cur.date}, {2'b0, last_day}, 8'h01);
        s_mon  = bcd_step({3'b0, cur.mon}, 8'h12, 8'h01);
        s_yr   = bcd_step(cur.yr, 8'h99, 8'h00);

        nxt     = cur;
        nxt.sec = s_sec[6:0];
        if (s_sec[8]) begin
            nxt.min = s_min[6:0];
            if (s_min[8]) begin
                nxt.hr = s_hr[5:0];
                if (s_hr[8]) begin
                    nxt.dow  = s_dow[2:0];
                    nxt.date = s_date[5:0];
                    if (s_date[8]) begin
                        nxt.mon = s_mon[4:0];
                        if (s_mon[8]) begin
                            nxt.yr = s_yr[7:0];
                            if (s_yr[8] && cen) nxt.cb = ~cur.cb;
                        end
                    end
                end
            end
        end
    end

    assign step_unused = ^{s_sec[7], s_min[7], s_hr[7:6], s_dow[7:3],
                           s_date[7:6], s_mon[7:5], s_dow[8]};
endmodule

// File: rtl/rtc_reg_read.sv
module rtc_reg_read
    import rtc_pkg::*;
(
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [REG_DATA_W-1:0] ctrl_byte,
    input  rtc_time_t             vis,
    input  logic                  stop,
    input  logic                  ftest,
    input  logic                  cen,
    input  logic                  ble,
    output logic [REG_DATA_W-1:0] rdata
);
    always_comb begin
        case (addr)
            A_CTRL:  rdata = ctrl_byte;
            A_SEC:   rdata = {stop, vis.sec};
            A_MIN:   rdata = {1'b0, vis.min};
            A_HR:    rdata = {2'b0, vis.hr};
            A_DAY:   rdata = {1'b0, ftest, cen, vis.cb, 1'b0, vis.dow};
            A_DATE:  rdata = {ble, 1'b0, vis.date};
            A_MON:   rdata = {3'b0, vis.mon};
            default: rdata = vis.yr;
        endcase
    end
endmodule

// File: rtl/rtc_bcd_bank.sv
module rtc_bcd_bank
    import rtc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_1hz,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic                  reg_wr,
    input  logic [REG_DATA_W-1:0] reg_wdata,
    output logic [REG_DATA_W-1:0] reg_rdata
);
    rtc_state_t st_d, st_q;
    rtc_time_t  live_adv;
    logic       ctrl_wr;
    logic       load_go;

    rtc_time_adv u_adv (
        .cur(st_q.live),
        .cen(st_q.cen),
        .nxt(live_adv)
    );

    rtc_reg_read u_rd (
        .addr     (reg_addr),
        .ctrl_byte({st_q.wr_f, st_q.rd_f, st_q.cal_sign, st_q.cal_mag}),
        .vis      (st_q.vis),
        .stop     (st_q.stop),
        .ftest    (st_q.ftest),
        .cen      (st_q.cen),
        .ble      (st_q.ble),
        .rdata    (reg_rdata)
    );

    always_comb begin
        st_d    = st_q;
        ctrl_wr = reg_wr && (reg_addr == A_CTRL);
        load_go = ctrl_wr && st_q.wr_f && !reg_wdata[7];

        // running counters: load has priority over the seconds tick
        if (load_go) begin
            st_d.live = st_q.vis;
        end else if (tick_1hz && !st_q.stop) begin
            st_d.live = live_adv;
        end

        // visible copy: track, or accept writes while loading
        if (!st_q.wr_f && !st_q.rd_f) begin
            st_d.vis = st_q.live;
        end else if (st_q.wr_f && reg_wr) begin
            case (reg_addr)
                A_SEC:  st_d.vis.sec  = reg_wdata[6:0];
                A_MIN:  st_d.vis.min  = reg_wdata[6:0];
                A_HR:   st_d.vis.hr   = reg_wdata[5:0];
                A_DAY: begin
                    st_d.vis.dow = reg_wdata[2:0];
                    st_d.vis.cb  = reg_wdata[4];
                end
                A_DATE: st_d.vis.date = reg_wdata[5:0];
                A_MON:  st_d.vis.mon  = reg_wdata[4:0];
                A_YEAR: st_d.vis.yr   = reg_wdata;
                default: ;
            endcase
        end

        // configuration bits, written regardless of the load flag
        if (ctrl_wr) begin
            st_d.wr_f     = reg_wdata[7];
            st_d.rd_f     = reg_wdata[6];
            st_d.cal_sign = reg_wdata[5];
            st_d.cal_mag  = reg_wdata[4:0];
        end
        if (reg_wr) begin
            case (reg_addr)
                A_SEC:  st_d.stop = reg_wdata[7];
                A_DAY: begin
                    st_d.ftest = reg_wdata[6];
                    st_d.cen   = reg_wdata[5];
                end
                A_DATE: st_d.ble = reg_wdata[7];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= STATE_RST;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rtc_bcd_bank_chk.sv
module rtc_bcd_bank_chk
    import rtc_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  tick_1hz,
    input logic [REG_ADDR_W-1:0] reg_addr,
    input logic                  reg_wr,
    input logic [REG_DATA_W-1:0] reg_wdata,
    input logic [REG_DATA_W-1:0] reg_rdata,
    input rtc_state_t            st_q
);
    logic release_wr;
    assign release_wr = reg_wr && (reg_addr == A_CTRL) && !reg_wdata[7] && st_q.wr_f;

    a_r2_tick_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1hz && !st_q.stop && !release_wr) |=> (st_q.live.sec != $past(st_q.live.sec)));

    a_r5_cb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.cen && !release_wr) |=> $stable(st_q.live.cb));

    a_r6_load_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.wr_f && !reg_wr) |=> $stable(st_q.vis));

    a_r7_load_all: assert property (@(posedge clk) disable iff (!rst_n)
        release_wr |=> (st_q.live == $past(st_q.vis)));

    a_r8_track_live: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.wr_f && !st_q.rd_f) |=> (st_q.vis == $past(st_q.live)));

    a_r9_snapshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rd_f && !st_q.wr_f) |=> $stable(st_q.vis));

    a_r10_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stop && !release_wr) |=> $stable(st_q.live));

    a_r11_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_addr == A_MIN  && reg_rdata[7]      == 1'b0) ||
         (reg_addr == A_HR   && reg_rdata[7:6]    == 2'b0) ||
         (reg_addr == A_DAY  && reg_rdata[7]      == 1'b0 && reg_rdata[3] == 1'b0) ||
         (reg_addr == A_DATE && reg_rdata[6]      == 1'b0) ||
         (reg_addr == A_MON  && reg_rdata[7:5]    == 3'b0) ||
         reg_addr == A_CTRL || reg_addr == A_SEC || reg_addr == A_YEAR));
endmodule

bind rtc_bcd_bank rtc_bcd_bank_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_1hz (tick_1hz),
    .reg_addr (reg_addr),
    .reg_wr   (reg_wr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .st_q     (st_q)
);

// File: tb/rtc_bcd_bank_tb_top.sv
module rtc_bcd_bank_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wd = 8'd0;
    logic [7:0] rd;

    always #4 clk = ~clk;   // 125 MHz

    rtc_bcd_bank dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_1hz (tick),
        .reg_addr (addr),
        .reg_wr   (wr),
        .reg_wdata(wd),
        .reg_rdata(rd)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    // ---------------- behavioural reference model ----------------
    // index 0 = century flag, 1 sec, 2 min, 3 hour, 4 dow, 5 date, 6 month, 7 year (binary)
    int m_live[8];
    int m_vis[8];
    bit m_wf, m_rf, m_sign, m_stop, m_ft, m_cen, m_ble;
    int m_mag;

    function automatic int tobcd(int v);
        return ((v / 10) << 4) | (v % 10);
    endfunction

    function automatic int frombcd(int b);
        return ((b >> 4) & 15) * 10 + (b & 15);
    endfunction

    function automatic int days_in(int mon, int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    task automatic m_reset();
        m_live = '{0, 0, 0, 0, 1, 1, 1, 0};
        m_vis  = m_live;
        {m_wf, m_rf, m_sign, m_stop, m_ft, m_cen, m_ble} = '0;
        m_mag = 0;
    endtask

    task automatic m_advance();
        m_live[1]++;
        if (m_live[1] >= 60) begin
            m_live[1] = 0;
            m_live[2]++;
            if (m_live[2] >= 60) begin
                m_live[2] = 0;
                m_live[3]++;
                if (m_live[3] >= 24) begin
                    m_live[3] = 0;
                    m_live[4] = (m_live[4] >= 7) ? 1 : m_live[4] + 1;
                    if (m_live[5] >= days_in(m_live[6], m_live[7])) begin
                        m_live[5] = 1;
                        m_live[6]++;
                        if (m_live[6] > 12) begin
                            m_live[6] = 1;
                            m_live[7]++;
                            if (m_live[7] > 99) begin
                                m_live[7] = 0;
                                if (m_cen) m_live[0] ^= 1;
                            end
                        end
                    end else begin
                        m_live[5]++;
                    end
                end
            end
        end
    endtask

    function automatic int m_read(int a);
        case (a)
            0: return (int'(m_wf) << 7) | (int'(m_rf) << 6) | (int'(m_sign) << 5) | m_mag;
            1: return (int'(m_stop) << 7) | tobcd(m_vis[1]);
            2: return tobcd(m_vis[2]);
            3: return tobcd(m_vis[3]);
            4: return (int'(m_ft) << 6) | (int'(m_cen) << 5) | (m_vis[0] << 4) | m_vis[4];
            5: return (int'(m_ble) << 7) | tobcd(m_vis[5]);
            6: return tobcd(m_vis[6]);
            default: return tobcd(m_vis[7]);
        endcase
    endfunction

    function automatic string tag_of(int a);
        case (a)
            0: return "R12";
            4: return "R5";
            5: return "R3";
            6, 7: return "R4";
            default: return "R2";
        endcase
    endfunction

    always @(posedge clk) begin
        int  old_live[8];
        bit  ld;
        if (!rst_n) begin
            m_reset();
        end else begin
            old_live = m_live;
            ld = wr && addr == 3'd0 && !wd[7] && m_wf;
            if (ld) m_live = m_vis;
            else if (tick && !m_stop) m_advance();
            if (!m_wf && !m_rf) begin
                m_vis = old_live;
            end else if (m_wf && wr) begin
                case (addr)
                    3'd1: m_vis[1] = frombcd(int'(wd) & 'h7F);
                    3'd2: m_vis[2] = frombcd(int'(wd) & 'h7F);
                    3'd3: m_vis[3] = frombcd(int'(wd) & 'h3F);
                    3'd4: begin m_vis[4] = int'(wd) & 7; m_vis[0] = int'(wd[4]); end
                    3'd5: m_vis[5] = frombcd(int'(wd) & 'h3F);
                    3'd6: m_vis[6] = frombcd(int'(wd) & 'h1F);
                    3'd7: m_vis[7] = frombcd(int'(wd));
                    default: ;
                endcase
            end
            if (wr) begin
                case (addr)
                    3'd0: begin
                        m_wf = wd[7]; m_rf = wd[6]; m_sign = wd[5]; m_mag = int'(wd[4:0]);
                    end
                    3'd1: m_stop = wd[7];
                    3'd4: begin m_ft = wd[6]; m_cen = wd[5]; end
                    3'd5: m_ble = wd[7];
                    default: ;
                endcase
            end
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        logic [7:0] e;
        if (rst_n && !done) begin
            e = 8'(m_read(int'(addr)));
            checks++;
            if (rd !== e) begin
                fails++;
                $display("FAIL %s model addr=%0d actual=%02h expected=%02h",
                         tag_of(int'(addr)), addr, rd, e);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc >= 50000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic drive(bit t, bit w, int a, int d);
        @(posedge clk);
        #1;
        tick = t; wr = w; addr = 3'(a); wd = 8'(d);
    endtask

    task automatic wr_reg(int a, int d);
        drive(0, 1, a, d);
        drive(0, 0, a, 0);
    endtask

    task automatic tick1();
        drive(1, 0, int'(addr), 0);
        drive(0, 0, int'(addr), 0);
    endtask

    task automatic expect_rd(int a, int exp, string req);
        drive(0, 0, a, 0);
        @(negedge clk);
        checks++;
        if (rd !== 8'(exp)) begin
            fails++;
            $display("FAIL %s addr=%0d actual=%02h expected=%02h", req, a, rd, 8'(exp));
        end
    endtask

    task automatic set_time(int s, int mi, int h, int dy, int dt, int mo, int y);
        wr_reg(0, 'h80);
        wr_reg(1, s);  wr_reg(2, mi); wr_reg(3, h);
        wr_reg(4, dy); wr_reg(5, dt); wr_reg(6, mo); wr_reg(7, y);
        wr_reg(0, 'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset values
        expect_rd(0, 'h00, "R1"); expect_rd(1, 'h00, "R1");
        expect_rd(2, 'h00, "R1"); expect_rd(3, 'h00, "R1");
        expect_rd(4, 'h01, "R1"); expect_rd(5, 'h01, "R1");
        expect_rd(6, 'h01, "R1"); expect_rd(7, 'h00, "R1");

        // R2/R4 full rollover, century disabled
        set_time('h58, 'h59, 'h23, 'h07, 'h31, 'h12, 'h99);
        expect_rd(1, 'h58, "R7");
        tick1(); expect_rd(1, 'h59, "R2");
        tick1();
        expect_rd(1, 'h00, "R2"); expect_rd(2, 'h00, "R2"); expect_rd(3, 'h00, "R2");
        expect_rd(4, 'h01, "R5"); expect_rd(5, 'h01, "R3");
        expect_rd(6, 'h01, "R4"); expect_rd(7, 'h00, "R4");

        // R12/R8 century-enable written without load flag, day field untouched
        wr_reg(4, 'h26);
        expect_rd(4, 'h21, "R8");
        set_time('h59, 'h59, 'h23, 'h27, 'h31, 'h12, 'h99);
        tick1();
        expect_rd(4, 'h31, "R5"); expect_rd(7, 'h00, "R4");
        wr_reg(4, 'h01);
        expect_rd(4, 'h11, "R12");
        set_time('h59, 'h59, 'h23, 'h07, 'h31, 'h12, 'h99);
        tick1();
        expect_rd(4, 'h01, "R5");

        // R3 month lengths and leap years
        set_time('h59, 'h59, 'h23, 'h03, 'h28, 'h02, 'h24);
        tick1(); expect_rd(5, 'h29, "R3"); expect_rd(6, 'h02, "R3");
        set_time('h59, 'h59, 'h23, 'h03, 'h29, 'h02, 'h24);
        tick1(); expect_rd(5, 'h01, "R3"); expect_rd(6, 'h03, "R3");
        set_time('h59, 'h59, 'h23, 'h03, 'h28, 'h02, 'h23);
        tick1(); expect_rd(5, 'h01, "R3"); expect_rd(6, 'h03, "R3");
        set_time('h59, 'h59, 'h23, 'h03, 'h28, 'h02, 'h00);
        tick1(); expect_rd(5, 'h29, "R3");
        set_time('h59, 'h59, 'h23, 'h03, 'h30, 'h04, 'h23);
        tick1(); expect_rd(5, 'h01, "R3"); expect_rd(6, 'h05, "R3");
        set_time('h59, 'h59, 'h23, 'h03, 'h30, 'h01, 'h23);
        tick1(); expect_rd(5, 'h31, "R3");

        // R2 decade carries
        set_time('h09, 'h00, 'h00, 'h02, 'h10, 'h05, 'h30);
        tick1(); expect_rd(1, 'h10, "R2");
        set_time('h59, 'h09, 'h12, 'h02, 'h10, 'h05, 'h30);
        tick1(); expect_rd(1, 'h00, "R2"); expect_rd(2, 'h10, "R2");

        // R8 time write ignored without load flag
        wr_reg(2, 'h33);
        expect_rd(2, 'h10, "R8");

        // R6 load flag freezes and accepts writes; R7 ticks during load discarded
        wr_reg(0, 'h80);
        wr_reg(2, 'h45);
        expect_rd(2, 'h45, "R6");
        tick1(); tick1();
        expect_rd(1, 'h00, "R6");
        wr_reg(0, 'h00);
        expect_rd(1, 'h00, "R7"); expect_rd(2, 'h45, "R7");

        // R7 tick in the release cycle is dropped
        wr_reg(0, 'h80);
        wr_reg(1, 'h30);
        drive(1, 1, 0, 'h00);
        drive(0, 0, 0, 0);
        expect_rd(1, 'h30, "R7");

        // R9 snapshot
        wr_reg(0, 'h40);
        tick1(); tick1(); tick1();
        expect_rd(1, 'h30, "R9");
        wr_reg(0, 'h00);
        expect_rd(1, 'h33, "R9");

        // R10 stop
        wr_reg(1, 'h80);
        expect_rd(1, 'hB3, "R10");
        tick1(); tick1();
        expect_rd(1, 'hB3, "R10");
        wr_reg(1, 'h00);
        tick1();
        expect_rd(1, 'h34, "R10");

        // R11 always-zero bits
        set_time('h00, 'hD9, 'hE3, 'h8F, 'hF1, 'hF2, 'h50);
        expect_rd(2, 'h59, "R11"); expect_rd(3, 'h23, "R11");
        expect_rd(4, 'h07, "R11"); expect_rd(5, 'hB1, "R11");
        expect_rd(6, 'h12, "R11");

        // R12 direct configuration bits
        wr_reg(0, 'h3A);
        expect_rd(0, 'h3A, "R12");
        wr_reg(4, 'h47);
        expect_rd(4, 'h47, "R12");

        repeat (4) @(posedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule